// File: doc/BRIEF.md
# Shadow L1 Tag Directory for Snoop Filtering

This block sits in an external second-level cache controller and keeps a copy of the tags held in a processor's set-associative first-level cache. It does not watch any cached data. Instead it decodes the processor's bus transactions: line fills, fills with intent to modify, their atomic forms, and block-kill operations. From these it works out which line the first-level cache has just taken in or dropped. The controller can then answer external snoops from this copy without probing the processor.

A snoop port compares an address against every way of the indexed set. One cycle later it reports a hit flag and a one-hot way. The copy is also updated when a fill pushes a dirty line into one of the processor's copy-back buffers. In that case the tag that was in the target slot leaves on an eviction output, together with its set index. A copy-back address queue takes it from there. A parameter selects between the data-side variant, which can raise the eviction output, and the instruction-side variant, which never does. A direct read port returns the valid bit and tag of any slot.

The default geometry is 4 ways and 128 sets, with 32-byte lines and 32-bit addresses. Each address therefore splits into a 20-bit tag, a 7-bit set index and a 5-bit line offset.

Top module: `snoop_filter_dir`

## Requirements
- R1: While reset (`rst_n` low) is applied, every valid bit is cleared. After reset, no snoop hits, `rd_valid` reads 0 for every slot, and `evict_valid` is 0.
- R2: A transaction with `bus_op` 1 (read), 2 (read with intent to modify), 3 (atomic read) or 4 (atomic read with intent to modify) and `bus_inhibit` low writes a valid entry. The entry holds tag `bus_addr[31:12]` at set `bus_addr[11:5]` in way `bus_way`. The entry is visible on the read port from the next cycle.
- R3: A read-class transaction with `bus_inhibit` high changes no entry and raises no eviction.
- R4: A kill-block transaction (`bus_op` 5) with `bus_tc[0]` high clears the valid bit of way `bus_way` in the addressed set.
- R5: A kill-block transaction with `bus_tc[0]` low and `bus_inhibit` low writes a valid entry, in the same way as R2.
- R6: In the cycle after `snoop_valid` is high, `snoop_hit` shows whether a valid entry in set `snoop_addr[11:5]` holds tag `snoop_addr[31:12]`, and `snoop_way` marks that way one-hot. In the cycle after `snoop_valid` is low, both read 0.
- R7: When a write and a snoop hit the same set in the same cycle, the snoop result includes that write.
- R8: On the data side, an allocation whose copy-back indication is set, and whose target slot held a valid entry, raises `evict_valid` for exactly the next cycle. During that cycle `evict_tag` and `evict_index` carry the old tag and the set. The copy-back indication is `bus_cb` for read-class operations and `bus_tc[2]` for kill-block allocations.
- R9: No eviction is raised when the target slot was invalid or when the copy-back indication is clear.
- R10: The instruction-side variant (`DATA_SIDE` = 0) never raises `evict_valid`.
- R11: `bus_op` codes 0, 6 and 7 change no entry and raise no eviction.
- R12: `rd_valid` and `rd_tag` show, in the same cycle, the stored state of slot (`rd_set`, `rd_way`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_op | input | 3 | Decoded processor transaction type |
| bus_addr | input | 32 | Transaction address |
| bus_inhibit | input | 1 | Cache-inhibit flag of the transaction |
| bus_way | input | 2 | Way chosen by the first-level cache |
| bus_tc | input | 3 | Transfer-code bits |
| bus_cb | input | 1 | Copy-back buffer used by a read-class fill |
| snoop_valid | input | 1 | Snoop compare request |
| snoop_addr | input | 32 | Snoop address |
| rd_set | input | 7 | Read port set index |
| rd_way | input | 2 | Read port way |
| rd_valid | output | 1 | Valid bit of the slot being read |
| rd_tag | output | 20 | Tag of the slot being read |
| snoop_hit | output | 1 | Registered snoop hit |
| snoop_way | output | 4 | Registered one-hot hit way |
| evict_valid | output | 1 | Displaced tag is presented |
| evict_tag | output | 20 | Displaced tag |
| evict_index | output | 7 | Set of the displaced tag |

## Verification
A slot written into the wrong way or the wrong set shows up on the next snoop of that address, which reports the wrong way or no hit one cycle after the request. A fault in write-first forwarding appears only when a snoop and a fill target the same set in the same cycle, so stimulus pairs them on purpose. A missed or wrongly captured old tag appears on `evict_tag` in the cycle right after the fill. Stale state that the snoop port does not reach is read back directly through the read port.

// File: rtl/snpf_pkg.sv
package snpf_pkg;

    typedef enum logic [2:0] {
        OP_IDLE       = 3'd0,
        OP_READ       = 3'd1,
        OP_RWITM      = 3'd2,
        OP_READ_ATOM  = 3'd3,
        OP_RWITM_ATOM = 3'd4,
        OP_KILL       = 3'd5
    } bus_op_e;

    typedef struct packed {
        logic wr_en;
        logic wr_valid;
        logic push_req;
    } dir_cmd_t;

    function automatic logic is_fill(input logic [2:0] op);
        return (op == OP_READ) || (op == OP_RWITM) ||
               (op == OP_READ_ATOM) || (op == OP_RWITM_ATOM);
    endfunction

endpackage

// File: rtl/snpf_decode.sv
module snpf_decode
    import snpf_pkg::*;
(
    input  logic [2:0] op,
    input  logic       inhibit,
    input  logic [2:0] tc,
    input  logic       cb,
    output dir_cmd_t   cmd
);

    always_comb begin
        cmd = '0;
        if (is_fill(op)) begin
            if (!inhibit) begin
                cmd.wr_en    = 1'b1;
                cmd.wr_valid = 1'b1;
                cmd.push_req = cb;
            end
        end else if (op == OP_KILL) begin
            if (tc[0]) begin
                cmd.wr_en    = 1'b1;
                cmd.wr_valid = 1'b0;
            end else if (!inhibit) begin
                cmd.wr_en    = 1'b1;
                cmd.wr_valid = 1'b1;
                cmd.push_req = tc[2];
            end
        end
    end

endmodule

// File: rtl/snpf_match.sv
module snpf_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 20
) (
    input  logic [WAYS-1:0]            vld,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           key,
    output logic [WAYS-1:0]            hits
);

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hits[w] = vld[w] && (tags[w] == key);
    end

endmodule

// File: rtl/snpf_dir.sv
module snpf_dir #(
    parameter int WAYS  = 4,
    parameter int SETS  = 128,
    parameter int TAG_W = 20,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_set,
    input  logic [WAY_W-1:0] wr_way,
    input  logic             wr_valid,
    input  logic [TAG_W-1:0] wr_tag,
    output logic             old_valid,
    output logic [TAG_W-1:0] old_tag,
    input  logic [IDX_W-1:0] rd_set,
    input  logic [WAY_W-1:0] rd_way,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic [IDX_W-1:0] snp_set,
    input  logic [TAG_W-1:0] snp_tag,
    output logic [WAYS-1:0]  snp_hits
);

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]            vld;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
    } dir_t;

    dir_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.vld[wr_set][wr_way] = wr_valid;
            if (wr_valid) begin
                st_d.tag[wr_set][wr_way] = wr_tag;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign old_valid = st_q.vld[wr_set][wr_way];
    assign old_tag   = st_q.tag[wr_set][wr_way];
    assign rd_valid  = st_q.vld[rd_set][rd_way];
    assign rd_tag    = st_q.tag[rd_set][rd_way];

    // Compare against the post-write view so a same-cycle fill is seen (R7).
    snpf_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_snoop_cmp (
        .vld  (st_d.vld[snp_set]),
        .tags (st_d.tag[snp_set]),
        .key  (snp_tag),
        .hits (snp_hits)
    );

    // R2 / R4: a write leaves the requested valid bit in the slot.
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.vld[$past(wr_set)][$past(wr_way)] == $past(wr_valid)));

    // R2: a valid write stores the tag.
    a_r2_tag_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_valid) |=> (st_q.tag[$past(wr_set)][$past(wr_way)] == $past(wr_tag)));

    // R11: with no write, the addressed slot stays unchanged.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q));

endmodule

// File: rtl/snoop_filter_dir.sv
module snoop_filter_dir
    import snpf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WAYS       = 4,
    parameter int SETS       = 128,
    parameter int LINE_BYTES = 32,
    parameter bit DATA_SIDE  = 1'b1,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_op,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_inhibit,
    input  logic [WAY_W-1:0]  bus_way,
    input  logic [2:0]        bus_tc,
    input  logic              bus_cb,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic [IDX_W-1:0]  rd_set,
    input  logic [WAY_W-1:0]  rd_way,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic              snoop_hit,
    output logic [WAYS-1:0]   snoop_way,
    output logic              evict_valid,
    output logic [TAG_W-1:0]  evict_tag,
    output logic [IDX_W-1:0]  evict_index
);

    typedef struct packed {
        logic             hit;
        logic [WAYS-1:0]  way;
        logic             ev;
        logic [TAG_W-1:0] etag;
        logic [IDX_W-1:0] eidx;
    } out_t;

    out_t out_d, out_q;

    dir_cmd_t         cmd;
    logic [TAG_W-1:0] bus_tag, snp_tag;
    logic [IDX_W-1:0] bus_set, snp_set;
    logic             old_valid;
    logic [TAG_W-1:0] old_tag;
    logic [WAYS-1:0]  snp_hits;
    logic             push_ok;

    assign bus_tag = bus_addr[ADDR_W-1 -: TAG_W];
    assign bus_set = bus_addr[OFF_W +: IDX_W];
    assign snp_tag = snoop_addr[ADDR_W-1 -: TAG_W];
    assign snp_set = snoop_addr[OFF_W +: IDX_W];

    snpf_decode u_decode (
        .op      (bus_op),
        .inhibit (bus_inhibit),
        .tc      (bus_tc),
        .cb      (bus_cb),
        .cmd     (cmd)
    );

    snpf_dir #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cmd.wr_en),
        .wr_set    (bus_set),
        .wr_way    (bus_way),
        .wr_valid  (cmd.wr_valid),
        .wr_tag    (bus_tag),
        .old_valid (old_valid),
        .old_tag   (old_tag),
        .rd_set    (rd_set),
        .rd_way    (rd_way),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .snp_set   (snp_set),
        .snp_tag   (snp_tag),
        .snp_hits  (snp_hits)
    );

    if (DATA_SIDE) begin : g_data_side
        assign push_ok = cmd.push_req && old_valid;
    end else begin : g_instr_side
        assign push_ok = 1'b0;
    end

    always_comb begin
        out_d      = '0;
        out_d.hit  = snoop_valid && (|snp_hits);
        out_d.way  = snoop_valid ? snp_hits : '0;
        out_d.ev   = push_ok;
        out_d.etag = push_ok ? old_tag : '0;
        out_d.eidx = push_ok ? bus_set : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign snoop_hit   = out_q.hit;
    assign snoop_way   = out_q.way;
    assign evict_valid = out_q.ev;
    assign evict_tag   = out_q.etag;
    assign evict_index = out_q.eidx;

    // R6: at most one way reported.
    a_r6_way_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(snoop_way));

    // R6: no request, no hit on the following cycle.
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !snoop_valid |=> (!snoop_hit && snoop_way == '0));

    // R3: inhibited fills never push.
    a_r3_inhibit_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        (is_fill(bus_op) && bus_inhibit) |=> !evict_valid);

    // R11: unused op codes never push.
    a_r11_unused_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_op == 3'd0 || bus_op == 3'd6 || bus_op == 3'd7) |=> !evict_valid);

    // R10: instruction side never pushes.
    a_r10_instr_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        !DATA_SIDE |-> !evict_valid);

    // R8: a push is a single-cycle pulse unless another allocation follows.
    a_r8_push_single: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_valid && !cmd.push_req) |=> !evict_valid);

endmodule

// File: tb/snoop_filter_dir_tb_top.sv
module snoop_filter_dir_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_op = '0;
    logic [31:0] bus_addr = '0;
    logic        bus_inhibit = 1'b0;
    logic [1:0]  bus_way = '0;
    logic [2:0]  bus_tc = '0;
    logic        bus_cb = 1'b0;
    logic        snoop_valid = 1'b0;
    logic [31:0] snoop_addr = '0;
    logic [6:0]  rd_set = '0;
    logic [1:0]  rd_way = '0;

    logic        rd_valid, i_rd_valid;
    logic [19:0] rd_tag, i_rd_tag;
    logic        snoop_hit, i_snoop_hit;
    logic [3:0]  snoop_way, i_snoop_way;
    logic        evict_valid, i_evict_valid;
    logic [19:0] evict_tag, i_evict_tag;
    logic [6:0]  evict_index, i_evict_index;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    snoop_filter_dir dut_i (
        .clk(clk), .rst_n(rst_n), .bus_op(bus_op), .bus_addr(bus_addr),
        .bus_inhibit(bus_inhibit), .bus_way(bus_way), .bus_tc(bus_tc),
        .bus_cb(bus_cb), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .rd_set(rd_set), .rd_way(rd_way), .rd_valid(rd_valid), .rd_tag(rd_tag),
        .snoop_hit(snoop_hit), .snoop_way(snoop_way), .evict_valid(evict_valid),
        .evict_tag(evict_tag), .evict_index(evict_index)
    );

    snoop_filter_dir #(.DATA_SIDE(1'b0)) dut_instr_i (
        .clk(clk), .rst_n(rst_n), .bus_op(bus_op), .bus_addr(bus_addr),
        .bus_inhibit(bus_inhibit), .bus_way(bus_way), .bus_tc(bus_tc),
        .bus_cb(bus_cb), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
        .rd_set(rd_set), .rd_way(rd_way), .rd_valid(i_rd_valid), .rd_tag(i_rd_tag),
        .snoop_hit(i_snoop_hit), .snoop_way(i_snoop_way), .evict_valid(i_evict_valid),
        .evict_tag(i_evict_tag), .evict_index(i_evict_index)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [19:0] tag;
        logic [6:0]  idx;
        logic        inh;
        logic [1:0]  way;
        logic [2:0]  tc;
        logic        cb;
        logic        s_en;
        logic [19:0] s_tag;
        logic [6:0]  s_idx;
        logic        x_hit;
        logic [3:0]  x_way;
        logic        x_ev;
        logic [19:0] x_etag;
        logic [31:0] req;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        // fill + snoop same set, same cycle: write first
        '{3'd1, 20'hA1, 7'd5, 1'b0, 2'd0, 3'd0, 1'b0, 1'b1, 20'hA1, 7'd5, 1'b1, 4'b0001, 1'b0, 20'h0, "R7  "},
        '{3'd2, 20'hB2, 7'd5, 1'b0, 2'd1, 3'd0, 1'b0, 1'b1, 20'hA1, 7'd5, 1'b1, 4'b0001, 1'b0, 20'h0, "R2  "},
        // inhibited fill leaves way 2 empty
        '{3'd1, 20'hC3, 7'd5, 1'b1, 2'd2, 3'd0, 1'b1, 1'b1, 20'hC3, 7'd5, 1'b0, 4'b0000, 1'b0, 20'h0, "R3  "},
        // atomic fill with copy-back over valid A1
        '{3'd3, 20'hD4, 7'd5, 1'b0, 2'd0, 3'd0, 1'b1, 1'b1, 20'hA1, 7'd5, 1'b0, 4'b0000, 1'b1, 20'hA1, "R8  "},
        // invalidate kill clears way 1
        '{3'd5, 20'hB2, 7'd5, 1'b0, 2'd1, 3'b001, 1'b0, 1'b1, 20'hB2, 7'd5, 1'b0, 4'b0000, 1'b0, 20'h0, "R4  "},
        // zeroing kill allocates way 0 with copy-back of D4
        '{3'd5, 20'hE5, 7'd5, 1'b0, 2'd0, 3'b100, 1'b0, 1'b1, 20'hE5, 7'd5, 1'b1, 4'b0001, 1'b1, 20'hD4, "R5  "},
        // copy-back flag over an empty slot: no push
        '{3'd4, 20'hF6, 7'd127, 1'b0, 2'd3, 3'd0, 1'b1, 1'b1, 20'hF6, 7'd127, 1'b1, 4'b1000, 1'b0, 20'h0, "R9  "},
        // unused code 6 ignored
        '{3'd6, 20'h11, 7'd127, 1'b0, 2'd3, 3'd0, 1'b1, 1'b1, 20'hF6, 7'd127, 1'b1, 4'b1000, 1'b0, 20'h0, "R11 "},
        // no snoop request: quiet output
        '{3'd0, 20'h0, 7'd0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, 20'hE5, 7'd5, 1'b0, 4'b0000, 1'b0, 20'h0, "R6  "}
    };

    function automatic logic [31:0] mk(input logic [19:0] t, input logic [6:0] i);
        return {t, i, 5'b0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        bus_op = 3'd0; bus_addr = '0; bus_inhibit = 1'b0; bus_way = '0;
        bus_tc = '0; bus_cb = 1'b0; snoop_valid = 1'b0; snoop_addr = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state
        for (int s = 0; s < 8; s++) begin
            rd_set = 7'(s * 17); rd_way = 2'(s);
            #1;
            chk("R1 rd_valid", {31'b0, rd_valid}, 32'd0);
        end
        snoop_valid = 1'b1; snoop_addr = mk(20'hA1, 7'd5);
        @(negedge clk);
        chk("R1 snoop_hit", {31'b0, snoop_hit}, 32'd0);
        chk("R1 evict_valid", {31'b0, evict_valid}, 32'd0);

        // table walk
        for (int k = 0; k < NV; k++) begin
            bus_op = TBL[k].op; bus_addr = mk(TBL[k].tag, TBL[k].idx);
            bus_inhibit = TBL[k].inh; bus_way = TBL[k].way;
            bus_tc = TBL[k].tc; bus_cb = TBL[k].cb;
            snoop_valid = TBL[k].s_en; snoop_addr = mk(TBL[k].s_tag, TBL[k].s_idx);
            @(negedge clk);
            chk($sformatf("%s step%0d hit", TBL[k].req, k), {31'b0, snoop_hit}, {31'b0, TBL[k].x_hit});
            chk($sformatf("%s step%0d way", TBL[k].req, k), {28'b0, snoop_way}, {28'b0, TBL[k].x_way});
            chk($sformatf("%s step%0d evict", TBL[k].req, k), {31'b0, evict_valid}, {31'b0, TBL[k].x_ev});
            if (TBL[k].x_ev) begin
                chk($sformatf("R8 step%0d etag", k), {12'b0, evict_tag}, {12'b0, TBL[k].x_etag});
                chk($sformatf("R8 step%0d eidx", k), {25'b0, evict_index}, {25'b0, TBL[k].idx});
            end
            chk($sformatf("R10 step%0d instr evict", k), {31'b0, i_evict_valid}, 32'd0);
            chk($sformatf("R10 step%0d instr hit", k), {31'b0, i_snoop_hit}, {31'b0, TBL[k].x_hit});
        end
        idle_inputs();

        // R12: read port contents after the walk
        rd_set = 7'd5; rd_way = 2'd0; #1;
        chk("R12 s5w0 valid", {31'b0, rd_valid}, 32'd1);
        chk("R12 s5w0 tag", {12'b0, rd_tag}, 32'hE5);
        rd_way = 2'd1; #1;
        chk("R4 s5w1 cleared", {31'b0, rd_valid}, 32'd0);
        rd_way = 2'd2; #1;
        chk("R3 s5w2 untouched", {31'b0, rd_valid}, 32'd0);
        rd_set = 7'd127; rd_way = 2'd3; #1;
        chk("R11 s127w3 tag kept", {12'b0, rd_tag}, 32'hF6);
        chk("R12 s127w3 valid", {31'b0, rd_valid}, 32'd1);

        // R8: pulse lasts one cycle
        @(negedge clk);
        chk("R8 pulse ends", {31'b0, evict_valid}, 32'd0);

        // R1: reset in mid-run wipes the copy
        do_reset();
        rd_set = 7'd5; rd_way = 2'd0; #1;
        chk("R1 wiped", {31'b0, rd_valid}, 32'd0);
        snoop_valid = 1'b1; snoop_addr = mk(20'hE5, 7'd5);
        @(negedge clk);
        chk("R1 snoop after reset", {31'b0, snoop_hit}, 32'd0);
        idle_inputs();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule